// File: doc/BRIEF.md
# Two-Group Prioritized Interrupt Controller

This block gathers fifteen interrupt lines, numbered 1 through 15, and records each rising edge as a pending bit. A bus master sets up the block through a word-wide register port. It programs which lines belong to the urgent group, which lines are broadcast, and a mask and a forced-interrupt set for each processor. The block returns one 4-bit request number to processor 0. That number names the line the processor should service next, and the value 0 means that nothing is due.

Processor 0 takes the highest-numbered enabled line, but only from the urgent group. The normal group is considered only when no urgent line is active. A broadcast line does not set the shared pending bit: it sets its forced bit in every processor's force set. When the processor has serviced a line, it reports that line's number on the acknowledge port. The block then removes that line from the shared pending set and from processor 0's forced set.

Top module: `irqc_top`

## Requirements
- R1: A synchronous reset clears every register. After reset, the request output is 0 and every mapped offset reads 0.
- R2: Lines pass through a two-flop synchroniser and an edge detector. A low-to-high change on line n sets pending bit n on the third rising clock edge after it is applied. A line held high does not set the bit again, and input bit 0 has no effect. The pending set reads at offset 0x04.
- R3: The broadcast select register is at offset 0x14. When bit n of that register is 1, a rising edge on line n sets bit n of every processor's force register and leaves the pending bit unchanged.
- R4: The enabled set is (pending OR force of processor 0) AND mask of processor 0. The request output is the highest-numbered enabled line in the winning group, or 0 when the set is empty. The mask registers start at offset 0x40, with processor c at 0x40+4c.
- R5: The level select register is at offset 0x00. Lines whose level bit is 1 form the urgent group, and this group wins over the normal group even when its line number is lower.
- R6: The force register of processor c is at offset 0x80+4c. A write to it sets the bits given in data[15:1] and clears the bits given in data[31:17]: new = (old | set) & ~clear.
- R7: Offset 0x08 reads processor 0's force register. A write to offset 0x08 replaces that register with data[15:1].
- R8: A write to offset 0x0C removes the bits given in data[15:1] from both the pending set and processor 0's force set. Offset 0x0C always reads 0.
- R9: A pulse on ack_valid with ack_num = n clears bit n in the pending set and in processor 0's force set on the next clock edge.
- R10: Writes to offset 0x04 and offset 0x10 are ignored, and offset 0x10 reads 0. Unmapped or misaligned offsets read 0. An access whose byte enables are not all ones has no effect.
- R11: A set and a clear of the same pending bit may arrive in the same cycle. In that case the set takes effect.
- R12: Bit 0 of any write to the level, broadcast, mask or force registers is discarded, so it always reads 0. Bit 16 of a force write is also discarded.
- R13: Each processor c has a 4-bit storage register at offset 0xC0+4c that keeps data[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq_in | input | 16 | Interrupt lines, asynchronous; bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Number of the serviced line |
| irq_req | output | 4 | Request number toward processor 0, 0 = none |

## Verification
Read data and the request number are combinational, so they are sampled on the falling edge. A register write or an acknowledge becomes visible at the falling edge after the single rising edge that captures it. A line edge takes three rising edges to reach the pending set, and the line tasks wait exactly that long before they read. The same-cycle test places the acknowledge on the third of those edges, so that the set and the clear meet on the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LINES   = 16;
    localparam int ID_W    = $clog2(LINES);
    localparam int CPU_W   = 4;
    localparam int EXT_W   = 4;

    typedef logic [LINES-1:0] line_vec_t;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_LEVEL,
        ACC_PEND,
        ACC_FORCE0,
        ACC_CLEAR,
        ACC_STATUS,
        ACC_BCAST,
        ACC_MASK,
        ACC_FORCE,
        ACC_EXT
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t        kind;
        logic [CPU_W-1:0] cpu;
    } acc_dec_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t pending;
        line_vec_t bcast;
    } glob_regs_t;

    // Offset decode: 0x00..0x3F global words, then three per-processor banks.
    function automatic acc_dec_t decode_off(input logic [7:0] a);
        acc_dec_t d;
        d.cpu  = a[5:2];
        d.kind = ACC_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[7:6])
                2'b00: begin
                    case (a[5:2])
                        4'h0:    d.kind = ACC_LEVEL;
                        4'h1:    d.kind = ACC_PEND;
                        4'h2:    d.kind = ACC_FORCE0;
                        4'h3:    d.kind = ACC_CLEAR;
                        4'h4:    d.kind = ACC_STATUS;
                        4'h5:    d.kind = ACC_BCAST;
                        default: d.kind = ACC_NONE;
                    endcase
                end
                2'b01:   d.kind = ACC_MASK;
                2'b10:   d.kind = ACC_FORCE;
                default: d.kind = ACC_EXT;
            endcase
        end
        return d;
    endfunction

    // Lines are 15:1; bit 0 never carries meaning.
    function automatic line_vec_t strip0(input logic [LINES-1:0] v);
        return {v[LINES-1:1], 1'b0};
    endfunction

    // Highest set index, 0 when empty.
    function automatic logic [ID_W-1:0] top_index(input line_vec_t v);
        logic [ID_W-1:0] idx;
        idx = '0;
        for (int i = 1; i < LINES; i++) begin
            if (v[i]) idx = ID_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge
    import irqc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t lines_in,
    output line_vec_t rise
);
    line_vec_t sync_q [STAGES];
    line_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= '0;
        else     sync_q[0] <= lines_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= '0;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise = strip0(sync_q[STAGES-1] & ~prev_q);

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_CPU = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [7:0]       acc_addr,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  line_vec_t        rise,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_num,
    output line_vec_t        pending,
    output line_vec_t        force0,
    output line_vec_t        mask0,
    output line_vec_t        level,
    output line_vec_t        bcast
);
    acc_dec_t   dec;
    logic       wr_hit;
    glob_regs_t g_q, g_d;
    line_vec_t  mask_q  [NUM_CPU];
    line_vec_t  force_q [NUM_CPU];
    logic [EXT_W-1:0] ext_q [NUM_CPU];
    line_vec_t  clr_all, pset, bset, wr_lo, wr_hi;
    logic       cpu_ok;

    assign dec    = decode_off(acc_addr);
    assign wr_hit = acc_en && acc_wr;
    assign cpu_ok = (int'(dec.cpu) < NUM_CPU);
    assign wr_lo  = strip0(acc_wdata[15:0]);
    assign wr_hi  = strip0(acc_wdata[31:16]);

    // Clear sources: acknowledge and clear-register write.
    always_comb begin
        clr_all = '0;
        if (ack_valid)
            clr_all[ack_num] = 1'b1;
        if (wr_hit && dec.kind == ACC_CLEAR)
            clr_all = clr_all | wr_lo;
        clr_all = strip0(clr_all);
    end

    assign bset = rise & g_q.bcast;
    assign pset = rise & ~g_q.bcast;

    always_comb begin
        g_d         = g_q;
        g_d.pending = (g_q.pending & ~clr_all) | pset;
        if (wr_hit && dec.kind == ACC_LEVEL) g_d.level = wr_lo;
        if (wr_hit && dec.kind == ACC_BCAST) g_d.bcast = wr_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_d;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic             sel_c;
        line_vec_t        force_d;
        assign sel_c = wr_hit && cpu_ok && (int'(dec.cpu) == c);

        always_comb begin
            force_d = force_q[c];
            if (sel_c && dec.kind == ACC_FORCE)
                force_d = (force_d | wr_lo) & ~wr_hi;
            if (c == 0) begin
                if (wr_hit && dec.kind == ACC_FORCE0)
                    force_d = wr_lo;
                force_d = force_d & ~clr_all;
            end
            force_d = force_d | bset;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[c]  <= '0;
                force_q[c] <= '0;
                ext_q[c]   <= '0;
            end else begin
                force_q[c] <= force_d;
                if (sel_c && dec.kind == ACC_MASK) mask_q[c] <= wr_lo;
                if (sel_c && dec.kind == ACC_EXT)  ext_q[c]  <= acc_wdata[EXT_W-1:0];
            end
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_wr) begin
            case (dec.kind)
                ACC_LEVEL:  acc_rdata = {16'h0, g_q.level};
                ACC_PEND:   acc_rdata = {16'h0, g_q.pending};
                ACC_FORCE0: acc_rdata = {16'h0, force_q[0]};
                ACC_BCAST:  acc_rdata = {16'h0, g_q.bcast};
                ACC_MASK:   if (cpu_ok) acc_rdata = {16'h0, mask_q[dec.cpu]};
                ACC_FORCE:  if (cpu_ok) acc_rdata = {16'h0, force_q[dec.cpu]};
                ACC_EXT:    if (cpu_ok) acc_rdata = {28'h0, ext_q[dec.cpu]};
                default:    acc_rdata = '0;
            endcase
        end
    end

    assign pending = g_q.pending;
    assign level   = g_q.level;
    assign bcast   = g_q.bcast;
    assign force0  = force_q[0];
    assign mask0   = mask_q[0];

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  line_vec_t       pending,
    input  line_vec_t       force0,
    input  line_vec_t       mask0,
    input  line_vec_t       level,
    output logic [ID_W-1:0] req
);
    line_vec_t active, urgent, normal, winner;

    always_comb begin
        active = (pending | force0) & mask0;
        urgent = active & level;
        normal = active & ~level;
        winner = (|urgent) ? urgent : normal;
        req    = top_index(winner);
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_CPU     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_be,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [15:0] irq_in,
    input  logic        ack_valid,
    input  logic [3:0]  ack_num,
    output logic [3:0]  irq_req
);
    line_vec_t rise_w, pend_w, force0_w, mask0_w, level_w, bcast_w;
    logic      acc_en;

    assign acc_en = bus_sel && (bus_be == 4'hF);

    irqc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .lines_in (irq_in),
        .rise     (rise_w)
    );

    irqc_regs #(.NUM_CPU(NUM_CPU)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_wr    (bus_wr),
        .acc_addr  (bus_addr),
        .acc_wdata (bus_wdata),
        .acc_rdata (bus_rdata),
        .rise      (rise_w),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .pending   (pend_w),
        .force0    (force0_w),
        .mask0     (mask0_w),
        .level     (level_w),
        .bcast     (bcast_w)
    );

    irqc_prio u_prio (
        .pending (pend_w),
        .force0  (force0_w),
        .mask0   (mask0_w),
        .level   (level_w),
        .req     (irq_req)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] pending,
    input logic [15:0] force0,
    input logic [15:0] mask0,
    input logic [15:0] level,
    input logic [15:0] bcast,
    input logic [15:0] rise,
    input logic        ack_valid,
    input logic [3:0]  ack_num,
    input logic [3:0]  irq_req
);
    logic [15:0] act;
    logic        rst_q;

    assign act = (pending | force0) & mask0;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: state is clear on the first edge after reset releases
    always @(posedge clk) begin
        if (!rst && rst_q)
            assert_reset_clear_R1: assert (pending == 16'h0 && force0 == 16'h0 && irq_req == 4'h0);
    end

    // R2: a pending bit only appears after a detected rising edge
    assert_pend_from_edge_R2: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & ~$past(rise)) == 16'h0));

    // R3: a broadcast line never lands in the pending set
    assert_bcast_not_pending_R3: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & $past(rise & bcast)) == 16'h0));

    // R4: a nonzero request names an enabled line; zero means none enabled
    assert_req_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_req != 4'h0) |-> act[irq_req]);
    assert_req_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_req == 4'h0) |-> (act[15:1] == 15'h0));

    // R5: a normal-group answer implies the urgent group is empty
    assert_urgent_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_req != 4'h0 && !level[irq_req]) |-> ((act & level) == 16'h0));

    // R9: acknowledged bit is gone next cycle unless a new edge set it
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !rise[ack_num]) |=> !pending[$past(ack_num)]);

endmodule

bind irqc_top irqc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pending   (pend_w),
    .force0    (force0_w),
    .mask0     (mask0_w),
    .level     (level_w),
    .bcast     (bcast_w),
    .rise      (rise_w),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .irq_req   (irq_req)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic [3:0]  irq_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irqc_top uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_num(ack_num), .irq_req(irq_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic raise(input int n);
        @(negedge clk);
        irq_in[n] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lower(input int n);
        @(negedge clk);
        irq_in[n] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack(input logic [3:0] n);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = n;
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "req after reset", {28'h0, irq_req}, 32'h0);
        chk_rd("R1", 8'h00, 32'h0);
        chk_rd("R1", 8'h04, 32'h0);
        chk_rd("R1", 8'h40, 32'h0);
        chk_rd("R1", 8'h80, 32'h0);
    endtask

    task automatic t_edge;
        wr(8'h40, 32'h0000_FFFF);
        chk_rd("R12", 8'h40, 32'h0000_FFFE);
        raise(5);
        chk_rd("R2", 8'h04, 32'h0000_0020);
        check("R4", "req line 5", {28'h0, irq_req}, 32'd5);
        raise(0);
        chk_rd("R2", 8'h04, 32'h0000_0020);
        // line 5 stays high: clearing must stick
        wr(8'h0C, 32'h0000_0020);
        chk_rd("R8", 8'h04, 32'h0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_rd("R2", 8'h04, 32'h0);
        chk_rd("R8", 8'h0C, 32'h0);
        lower(5);
        lower(0);
        raise(5);
    endtask

    task automatic t_priority;
        raise(3);
        chk_rd("R2", 8'h04, 32'h0000_0028);
        check("R4", "highest normal", {28'h0, irq_req}, 32'd5);
        wr(8'h00, 32'h0000_0009);
        chk_rd("R12", 8'h00, 32'h0000_0008);
        check("R5", "urgent low line wins", {28'h0, irq_req}, 32'd3);
        wr(8'h40, 32'h0000_FFF6);
        check("R4", "masked urgent", {28'h0, irq_req}, 32'd5);
    endtask

    task automatic t_ack;
        ack(4'd5);
        chk_rd("R9", 8'h04, 32'h0000_0008);
        check("R9", "req after ack", {28'h0, irq_req}, 32'd0);
        ack(4'd3);
        chk_rd("R9", 8'h04, 32'h0);
        lower(3);
        lower(5);
    endtask

    task automatic t_force;
        wr(8'h80, 32'h0001_0007);
        chk_rd("R6", 8'h80, 32'h0000_0006);
        wr(8'h80, 32'h0004_0010);
        chk_rd("R6", 8'h80, 32'h0000_0012);
        chk_rd("R7", 8'h08, 32'h0000_0012);
        check("R4", "forced request", {28'h0, irq_req}, 32'd4);
        wr(8'h8C, 32'h0000_8000);
        chk_rd("R6", 8'h8C, 32'h0000_8000);
        chk_rd("R6", 8'h80, 32'h0000_0012);
        wr(8'h08, 32'h0000_0003);
        chk_rd("R7", 8'h80, 32'h0000_0002);
        ack(4'd1);
        chk_rd("R9", 8'h08, 32'h0);
        wr(8'h08, 32'h0000_0014);
        wr(8'h0C, 32'h0000_0004);
        chk_rd("R8", 8'h08, 32'h0000_0010);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_bcast;
        wr(8'h14, 32'h0000_0401);
        chk_rd("R12", 8'h14, 32'h0000_0400);
        raise(10);
        chk_rd("R3", 8'h04, 32'h0);
        chk_rd("R3", 8'h80, 32'h0000_0400);
        chk_rd("R3", 8'h94, 32'h0000_0400);
        chk_rd("R3", 8'hBC, 32'h0000_0400);
        check("R3", "req broadcast", {28'h0, irq_req}, 32'd10);
        wr(8'h0C, 32'h0000_0400);
        chk_rd("R8", 8'h80, 32'h0);
        chk_rd("R3", 8'h94, 32'h0000_0400);
        lower(10);
        wr(8'h14, 32'h0);
    endtask

    task automatic t_ignored;
        raise(2);
        wr(8'h04, 32'h0000_FFFF);
        chk_rd("R10", 8'h04, 32'h0000_0004);
        wr(8'h10, 32'hFFFF_FFFF);
        chk_rd("R10", 8'h10, 32'h0);
        chk_rd("R10", 8'h30, 32'h0);
        chk_rd("R10", 8'h41, 32'h0);
        wr(8'h40, 32'h0, 4'h3);
        chk_rd("R10", 8'h40, 32'h0000_FFF6);
        ack(4'd2);
        lower(2);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        irq_in[7] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b1; ack_num = 4'd7;
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
        chk_rd("R11", 8'h04, 32'h0000_0080);
        ack(4'd7);
        lower(7);
    endtask

    task automatic t_ext;
        wr(8'hC4, 32'h0000_00FF);
        chk_rd("R13", 8'hC4, 32'h0000_000F);
        chk_rd("R13", 8'hC0, 32'h0);
    endtask

    initial begin
        #(4.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edge();
        t_priority();
        t_ack();
        t_force();
        t_bcast();
        t_ignored();
        t_set_wins();
        t_ext();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule